// File: doc/BRIEF.md
# SD/MMC Command Issue Sequencer

This block sits between a host register port and the command side of an SD/MMC card interface. A host loads a 6-bit command index, a 32-bit argument written as two independent 16-bit halves, and a control word. Then it starts the card clock. The sequencer issues the command on a valid/ready request port, waits busy for the card's response, and checks the response length against the selected response type. It then fills a nine-entry halfword response queue and posts completion or timeout status. When the control word announces a data phase, it also loads a byte counter with block count times block length.

The command goes out on whichever of two events comes second: the clock start or the control write. A stop-transfer flag in the control word keeps the command pending. Stopping the clock cancels whatever is in flight. The host drains the response queue one halfword per read of the response address. CRC, the serial line protocol and the card itself lie outside the block.

Register addresses on `addr`: 0 clock control (write), 1 status (read), 2 control word, 3 block length, 4 block count, 5 interrupt flags (read), 6 command index, 7 argument high, 8 argument low, 9 response queue (read, pops), 10 byte counter bits 15:0, 11 byte counter bits 31:16.

Top module: `sdcmd_seq`

## Requirements
- R1: A write to the control word (address 2) with stop-transfer (bit 10) clear raises `card_req_valid` in the next cycle if clock-enable status (address 1 bit 8) is already set. Otherwise the command stays pending and no request appears. With bit 10 set, no request is made.
- R2: A clock-control write (address 0) with start (bit 1) set and stop (bit 0) clear sets status bit 8 and clears clock-off interrupt (address 5 bit 4). If a command is pending and its stop-transfer bit is clear, it is issued. When bits 0 and 1 are both set, stop wins and nothing is issued.
- R3: A clock-control write with stop (bit 0) set does several things. It clears status bit 8 and sets interrupt bit 4. It drops any outstanding request and clears the active flag (status bit 0). A response offered afterwards is ignored, so status bits 13 and 1 and interrupt bit 2 stay clear.
- R4: The response type is control bits 1:0. Type 0 needs 0 bytes, types 1 and 3 need 4 bytes, and type 2 needs 16 bytes. A response with fewer bytes (`card_rsp_len`) sets status bit 1, clears status bit 0 and leaves every queue entry zero.
- R5: A response of sufficient length sets status bit 13. Entry k of the queue holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Bytes at or beyond the reported length read as zero. Issuing a new command clears status bits 1 and 13.
- R6: Reads of address 9 return the nine queue entries in order, one per read, starting from the first after each completion. Every read after the ninth returns 0.
- R7: If data-enable (control bit 2) is set, a successful response loads the byte counter (addresses 10/11) with block count × block length (12-bit length, 16-bit count) and keeps status bit 0 set. Otherwise status bit 0 clears.
- R8: Address 6 reads the 6-bit index ORed with 0x40. Writes to address 7 or 8 change only their own half of `card_arg`, and each half reads back unchanged.
- R9: Interrupt bit 2 (address 5) sets when a response is accepted, whether it succeeds or times out.
- R10: While `card_req_valid` is high and `card_req_ready` low, the request and `card_cmd`/`card_arg` hold until accepted. `card_rsp_ready` is high only while waiting for the response, never together with `card_req_valid`.
- R11: After reset, status, interrupt flags and queue reads are 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the response queue at address 9) |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| card_req_valid | output | 1 | Command request valid |
| card_req_ready | input | 1 | Card accepts the request |
| card_cmd | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Response valid |
| card_rsp_ready | output | 1 | Sequencer waits for a response |
| card_rsp_len | input | 5 | Number of valid response bytes (0 to 16) |
| card_rsp_data | input | 128 | Response bytes, byte 0 in bits 7:0 |

## Verification
The bench sweeps all four response types against lengths just below, at and above each threshold. The lengths include an odd count, which exposes a design that packs the high byte of the last pair from stale data or swaps the byte order in a halfword. It drives both orders of clock start and control write, so a design that launches only on one of them leaves the request low. It also drives a start and stop in one write, and a stop while the response is outstanding; there a design that did not cancel would post completion status from the late response. Data-phase counts include the largest block length times the largest block count, which catches a product truncated to 16 bits.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} sq_state_t;

   localparam logic [3:0] AD_CLK    = 4'd0;
   localparam logic [3:0] AD_STAT   = 4'd1;
   localparam logic [3:0] AD_CTL    = 4'd2;
   localparam logic [3:0] AD_BLKLEN = 4'd3;
   localparam logic [3:0] AD_NBLK   = 4'd4;
   localparam logic [3:0] AD_INT    = 4'd5;
   localparam logic [3:0] AD_CMD    = 4'd6;
   localparam logic [3:0] AD_ARGH   = 4'd7;
   localparam logic [3:0] AD_ARGL   = 4'd8;
   localparam logic [3:0] AD_RSP    = 4'd9;
   localparam logic [3:0] AD_CNTL   = 4'd10;
   localparam logic [3:0] AD_CNTH   = 4'd11;

   localparam int CK_STOP_B  = 0;
   localparam int CK_START_B = 1;

   localparam int ST_ACT_B    = 0;
   localparam int ST_TOUT_B   = 1;
   localparam int ST_CLKEN_B  = 8;
   localparam int ST_ENDRSP_B = 13;

   localparam int CT_DEN_B  = 2;
   localparam int CT_STOP_B = 10;

   localparam int IR_END_B    = 2;
   localparam int IR_CLKOFF_B = 4;

endpackage

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
   import sdcmd_pkg::*;
#(
   parameter int LEN_W     = 5,
   parameter int SHORT_RSP = 4,
   parameter int LONG_RSP  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             abort,
   input  logic [1:0]       rtype,
   input  logic             req_ready,
   input  logic             rsp_valid,
   input  logic [LEN_W-1:0] rsp_len,
   output logic             req_valid,
   output logic             rsp_ready,
   output logic             fin_ok,
   output logic             fin_tout
);

   localparam logic [LEN_W-1:0] NEED_S = LEN_W'(SHORT_RSP);
   localparam logic [LEN_W-1:0] NEED_L = LEN_W'(LONG_RSP);

   sq_state_t        st_q;
   logic [LEN_W-1:0] need;
   logic             fin_any;

   always_comb begin
      case (rtype)
         2'd0:    need = '0;
         2'd2:    need = NEED_L;
         default: need = NEED_S;
      endcase
   end

   assign req_valid = (st_q == SQ_REQ);
   assign rsp_ready = (st_q == SQ_WAIT) && !abort && !launch;
   assign fin_any   = rsp_ready && rsp_valid;
   assign fin_ok    = fin_any && (rsp_len >= need);
   assign fin_tout  = fin_any && (rsp_len < need);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SQ_IDLE;
      end else if (launch) begin
         st_q <= SQ_REQ;
      end else if (abort) begin
         st_q <= SQ_IDLE;
      end else begin
         case (st_q)
            SQ_REQ:  if (req_ready) st_q <= SQ_WAIT;
            SQ_WAIT: if (rsp_valid) st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdcmd_rspq.sv
module sdcmd_rspq #(
   parameter int DEPTH  = 9,
   parameter int NBYTES = 16,
   parameter int LEN_W  = 5,
   parameter int PTR_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LEN_W-1:0]    len,
   input  logic [NBYTES*8-1:0] bytes,
   input  logic                pop,
   output logic [15:0]         head,
   output logic [PTR_W-1:0]    ptr
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [15:0] mem [DEPTH];
   logic [15:0] packed_w [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_pack
      if (2 * k + 1 < NBYTES) begin : g_full
         assign packed_w[k][7:0]  = (len > LEN_W'(2 * k))     ? bytes[(2*k)*8 +: 8]   : 8'h00;
         assign packed_w[k][15:8] = (len > LEN_W'(2 * k + 1)) ? bytes[(2*k+1)*8 +: 8] : 8'h00;
      end else if (2 * k < NBYTES) begin : g_half
         assign packed_w[k][7:0]  = (len > LEN_W'(2 * k)) ? bytes[(2*k)*8 +: 8] : 8'h00;
         assign packed_w[k][15:8] = 8'h00;
      end else begin : g_none
         assign packed_w[k] = 16'h0000;
      end
   end

   assign head = (ptr < PTR_W'(DEPTH)) ? mem[ptr[IDX_W-1:0]] : 16'h0000;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (load) begin
         ptr <= '0;
         for (int k = 0; k < DEPTH; k++) mem[k] <= packed_w[k];
      end else if (pop && (ptr < PTR_W'(DEPTH))) begin
         ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
   import sdcmd_pkg::*;
#(
   parameter int CMD_W     = 6,
   parameter int RSP_BYTES = 16,
   parameter int RSPQ_DEPTH = 9,
   parameter int SHORT_RSP = 4,
   parameter int BLKLEN_W  = 12,
   parameter int NBLK_W    = 16,
   parameter int CTL_W     = 14,
   parameter logic [CTL_W-1:0] CTL_MASK = 14'h3dff,
   localparam int LEN_W    = $clog2(RSP_BYTES + 1),
   localparam int CNT_W    = BLKLEN_W + NBLK_W,
   localparam int PTR_W    = $clog2(RSPQ_DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [3:0]             addr,
   input  logic [15:0]            wdata,
   output logic [15:0]            rdata,
   output logic                   card_req_valid,
   input  logic                   card_req_ready,
   output logic [CMD_W-1:0]       card_cmd,
   output logic [31:0]            card_arg,
   input  logic                   card_rsp_valid,
   output logic                   card_rsp_ready,
   input  logic [LEN_W-1:0]       card_rsp_len,
   input  logic [RSP_BYTES*8-1:0] card_rsp_data
);

   if (RSPQ_DEPTH * 2 < RSP_BYTES) begin : g_bad_depth
      $error("response queue too shallow for the longest response");
   end
   if (CNT_W > 32) begin : g_bad_cnt
      $error("byte counter exceeds its two readout halves");
   end
   if (CMD_W > 6 || CTL_W > 16 || BLKLEN_W > 16 || NBLK_W > 16) begin : g_bad_w
      $error("register field wider than the host data path");
   end

   logic                clk_en_q, pend_q, active_q, tout_q, endrsp_q;
   logic                int_end_q, int_clkoff_q;
   logic [CTL_W-1:0]    ctl_q;
   logic [BLKLEN_W-1:0] blklen_q;
   logic [NBLK_W-1:0]   nblk_q;
   logic [CMD_W-1:0]    cmd_q;
   logic [31:0]         arg_q;
   logic [CNT_W-1:0]    cnt_q;

   logic wr_clk, wr_ctl, ck_start, ck_stop, ctl_go;
   logic launch, abort, fin_ok, fin_tout, pop;
   logic [15:0]      q_head;
   logic [PTR_W-1:0] q_ptr;
   logic [31:0]      cnt32;

   assign wr_clk   = wr_en && (addr == AD_CLK);
   assign wr_ctl   = wr_en && (addr == AD_CTL);
   assign ck_start = wr_clk && wdata[CK_START_B] && !wdata[CK_STOP_B];
   assign ck_stop  = wr_clk && wdata[CK_STOP_B];
   assign ctl_go   = wr_ctl && !wdata[CT_STOP_B];
   assign launch   = (ctl_go && clk_en_q) ||
                     (ck_start && pend_q && !ctl_q[CT_STOP_B]);
   assign abort    = wr_ctl || ck_stop;
   assign pop      = rd_en && (addr == AD_RSP);

   sdcmd_fsm #(
      .LEN_W     (LEN_W),
      .SHORT_RSP (SHORT_RSP),
      .LONG_RSP  (RSP_BYTES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .abort     (abort),
      .rtype     (ctl_q[1:0]),
      .req_ready (card_req_ready),
      .rsp_valid (card_rsp_valid),
      .rsp_len   (card_rsp_len),
      .req_valid (card_req_valid),
      .rsp_ready (card_rsp_ready),
      .fin_ok    (fin_ok),
      .fin_tout  (fin_tout)
   );

   sdcmd_rspq #(
      .DEPTH  (RSPQ_DEPTH),
      .NBYTES (RSP_BYTES),
      .LEN_W  (LEN_W),
      .PTR_W  (PTR_W)
   ) u_rspq (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fin_ok || fin_tout),
      .len   (fin_ok ? card_rsp_len : '0),
      .bytes (card_rsp_data),
      .pop   (pop),
      .head  (q_head),
      .ptr   (q_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_en_q     <= 1'b0;
         pend_q       <= 1'b0;
         active_q     <= 1'b0;
         tout_q       <= 1'b0;
         endrsp_q     <= 1'b0;
         int_end_q    <= 1'b0;
         int_clkoff_q <= 1'b0;
         ctl_q        <= '0;
         blklen_q     <= '0;
         nblk_q       <= '0;
         cmd_q        <= '0;
         arg_q        <= '0;
         cnt_q        <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               AD_CTL:    ctl_q    <= wdata[CTL_W-1:0] & CTL_MASK;
               AD_BLKLEN: blklen_q <= wdata[BLKLEN_W-1:0];
               AD_NBLK:   nblk_q   <= wdata[NBLK_W-1:0];
               AD_CMD:    cmd_q    <= wdata[CMD_W-1:0];
               AD_ARGH:   arg_q[31:16] <= wdata;
               AD_ARGL:   arg_q[15:0]  <= wdata;
               default: ;
            endcase
         end

         if (ck_stop) begin
            clk_en_q     <= 1'b0;
            int_clkoff_q <= 1'b1;
         end else if (ck_start) begin
            clk_en_q     <= 1'b1;
            int_clkoff_q <= 1'b0;
         end

         if (launch)      pend_q <= 1'b0;
         else if (wr_ctl) pend_q <= 1'b1;

         if (launch)        active_q <= 1'b1;
         else if (abort)    active_q <= 1'b0;
         else if (fin_tout) active_q <= 1'b0;
         else if (fin_ok && !ctl_q[CT_DEN_B]) active_q <= 1'b0;

         if (launch || ctl_go) begin
            tout_q   <= 1'b0;
            endrsp_q <= 1'b0;
         end else begin
            if (fin_tout) tout_q   <= 1'b1;
            if (fin_ok)   endrsp_q <= 1'b1;
         end

         if (fin_ok || fin_tout) int_end_q <= 1'b1;

         if (fin_ok && ctl_q[CT_DEN_B]) cnt_q <= CNT_W'(nblk_q) * CNT_W'(blklen_q);
      end
   end

   assign card_cmd = cmd_q;
   assign card_arg = arg_q;
   assign cnt32    = 32'(cnt_q);

   always_comb begin
      rdata = 16'h0000;
      case (addr)
         AD_STAT: begin
            rdata[ST_ACT_B]    = active_q;
            rdata[ST_TOUT_B]   = tout_q;
            rdata[ST_CLKEN_B]  = clk_en_q;
            rdata[ST_ENDRSP_B] = endrsp_q;
         end
         AD_CTL:    rdata = 16'(ctl_q);
         AD_BLKLEN: rdata = 16'(blklen_q);
         AD_NBLK:   rdata = 16'(nblk_q);
         AD_INT: begin
            rdata[IR_END_B]    = int_end_q;
            rdata[IR_CLKOFF_B] = int_clkoff_q;
         end
         AD_CMD:    rdata = 16'(cmd_q) | 16'h0040;
         AD_ARGH:   rdata = arg_q[31:16];
         AD_ARGL:   rdata = arg_q[15:0];
         AD_RSP:    rdata = q_head;
         AD_CNTL:   rdata = cnt32[15:0];
         AD_CNTH:   rdata = cnt32[31:16];
         default:   rdata = 16'h0000;
      endcase
   end

endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk #(
   parameter int CMD_W = 6,
   parameter int PTR_W = 4,
   parameter int DEPTH = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       addr,
   input logic [15:0]      wdata,
   input logic             card_req_valid,
   input logic             card_req_ready,
   input logic             card_rsp_ready,
   input logic [CMD_W-1:0] card_cmd,
   input logic [31:0]      card_arg,
   input logic             clk_en_q,
   input logic             active_q,
   input logic             tout_q,
   input logic             endrsp_q,
   input logic [PTR_W-1:0] q_ptr
);

   // R10: an unaccepted request keeps its contents
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (card_req_valid && !card_req_ready && !wr_en) |=>
      (card_req_valid && $stable(card_cmd) && $stable(card_arg)));

   // R10: never offering a request and awaiting a response together
   a_r10_hs_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_req_valid && card_rsp_ready));

   // R1: a request only appears with the clock enabled
   a_r1_launch_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_req_valid) |-> clk_en_q);

   // R3: stopping the clock cancels everything in flight
   a_r3_stop_kills: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'd0 && wdata[0]) |=>
      (!card_req_valid && !card_rsp_ready && !active_q && !clk_en_q));

   // R4: timeout and end-of-response status are never set together
   a_r4_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(tout_q && endrsp_q));

   // R6: the read pointer never runs past the queue
   a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_ptr <= PTR_W'(DEPTH));

endmodule

bind sdcmd_seq sdcmd_seq_chk #(
   .CMD_W (CMD_W),
   .PTR_W (PTR_W),
   .DEPTH (RSPQ_DEPTH)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .addr           (addr),
   .wdata          (wdata),
   .card_req_valid (card_req_valid),
   .card_req_ready (card_req_ready),
   .card_rsp_ready (card_rsp_ready),
   .card_cmd       (card_cmd),
   .card_arg       (card_arg),
   .clk_en_q       (clk_en_q),
   .active_q       (active_q),
   .tout_q         (tout_q),
   .endrsp_q       (endrsp_q),
   .q_ptr          (q_ptr)
);

// File: tb/tb_sdcmd_seq.sv
module tb_sdcmd_seq;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]   addr = '0;
   logic [15:0]  wdata = '0;
   logic [15:0]  rdata;
   logic         card_req_valid, card_rsp_ready;
   logic         card_req_ready = 1'b0, card_rsp_valid = 1'b0;
   logic [5:0]   card_cmd;
   logic [31:0]  card_arg;
   logic [4:0]   card_rsp_len = '0;
   logic [127:0] card_rsp_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdcmd_seq dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .card_req_valid(card_req_valid),
      .card_req_ready(card_req_ready), .card_cmd(card_cmd), .card_arg(card_arg),
      .card_rsp_valid(card_rsp_valid), .card_rsp_ready(card_rsp_ready),
      .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 0; rd_en = 0;
      card_req_ready = 0; card_rsp_valid = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] bval(input int cmd, input int i);
      return 8'((cmd * 7 + i * 13 + 1) & 255);
   endfunction

   // accept the pending request and answer with len bytes
   task automatic serve(input int cmd, input int len);
      int n = 0;
      while (!card_req_valid && n < 50) begin @(negedge clk); n++; end
      card_req_ready = 1'b1;
      @(negedge clk);
      card_req_ready = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 16; i++) card_rsp_data[i*8 +: 8] = bval(cmd, i);
      card_rsp_len = 5'(len);
      card_rsp_valid = 1'b1;
      @(negedge clk);
      card_rsp_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int need;
      bit ok;
      int lens [7] = '{0, 2, 3, 4, 5, 15, 16};
      int blks [4] = '{4095, 0, 1, 512};
      int nums [4] = '{65535, 5, 1, 3};

      // R11 reset state
      do_reset();
      rd(4'd1, d); check("R11 status", 32'(d), 0);
      rd(4'd5, d); check("R11 int", 32'(d), 0);
      rd(4'd9, d); check("R11 rsp", 32'(d), 0);
      check("R11 req", 32'(card_req_valid), 0);

      // R4 R5 R6 R9 sweep of type against length
      for (int t = 0; t < 4; t++) begin
         for (int li = 0; li < 7; li++) begin
            int cmd = t * 7 + li + 1;
            need = (t == 0) ? 0 : (t == 2) ? 16 : 4;
            ok = (lens[li] >= need);
            do_reset();
            wr(4'd6, 16'(cmd));
            wr(4'd0, 16'h0002);
            wr(4'd2, 16'(t));
            check("R1 launch", 32'(card_req_valid), 1);
            serve(cmd, lens[li]);
            rd(4'd1, d);
            check("R5 end status", 32'(d[13]), 32'(ok));
            check("R4 timeout status", 32'(d[1]), 32'(!ok));
            check("R7 idle w/o data", 32'(d[0]), 0);
            rd(4'd5, d); check("R9 end int", 32'(d[2]), 1);
            for (int k = 0; k < 9; k++) begin
               logic [15:0] e;
               e = 16'h0;
               if (ok && 2*k < lens[li])   e[7:0]  = bval(cmd, 2*k);
               if (ok && 2*k+1 < lens[li]) e[15:8] = bval(cmd, 2*k+1);
               rd(4'd9, d); check("R5 R6 rsp entry", 32'(d), 32'(e));
            end
            rd(4'd9, d); check("R6 drained", 32'(d), 0);
         end
      end

      // R7 data-phase byte count
      for (int j = 0; j < 4; j++) begin
         logic [15:0] lo, hi;
         do_reset();
         wr(4'd3, 16'(blks[j]));
         wr(4'd4, 16'(nums[j]));
         wr(4'd0, 16'h0002);
         wr(4'd2, 16'h0005);
         serve(3, 4);
         rd(4'd10, lo); rd(4'd11, hi);
         check("R7 count", {hi, lo}, 32'(blks[j] * nums[j]));
         rd(4'd1, d); check("R7 active", 32'(d[0]), 1);
      end

      // R1 control first, then R2 clock start issues it
      do_reset();
      wr(4'd2, 16'h0001);
      repeat (4) @(negedge clk);
      check("R1 pending no req", 32'(card_req_valid), 0);
      wr(4'd0, 16'h0002);
      check("R2 start issues", 32'(card_req_valid), 1);
      serve(9, 4);
      rd(4'd1, d); check("R2 completion", 32'(d), 32'h2100);

      // R1 stop-transfer holds the command
      do_reset();
      wr(4'd0, 16'h0002);
      wr(4'd2, 16'h0401);
      repeat (3) @(negedge clk);
      check("R1 stop_tran no req", 32'(card_req_valid), 0);
      wr(4'd0, 16'h0002);
      check("R2 stop_tran no req", 32'(card_req_valid), 0);

      // R2 start and stop together: stop wins
      do_reset();
      wr(4'd2, 16'h0001);
      wr(4'd0, 16'h0003);
      check("R2 both no req", 32'(card_req_valid), 0);
      rd(4'd1, d); check("R2 both clk off", 32'(d[8]), 0);
      rd(4'd5, d); check("R2 both clkoff int", 32'(d[4]), 1);

      // R3 stop while waiting for the response
      do_reset();
      wr(4'd0, 16'h0002);
      wr(4'd2, 16'h0001);
      card_req_ready = 1'b1;
      @(negedge clk);
      card_req_ready = 1'b0;
      check("R10 waiting", 32'(card_rsp_ready), 1);
      wr(4'd0, 16'h0001);
      check("R3 rsp_ready dropped", 32'(card_rsp_ready), 0);
      card_rsp_len = 5'd16; card_rsp_valid = 1'b1;
      @(negedge clk);
      card_rsp_valid = 1'b0;
      rd(4'd1, d); check("R3 status after stop", 32'(d), 0);
      rd(4'd5, d); check("R3 int after stop", 32'(d), 32'h0010);
      wr(4'd0, 16'h0002);
      rd(4'd5, d); check("R2 start clears clkoff", 32'(d), 0);
      rd(4'd1, d); check("R2 clk enabled", 32'(d), 32'h0100);

      // R10 request held until accepted
      do_reset();
      wr(4'd6, 16'h0011);
      wr(4'd0, 16'h0002);
      wr(4'd2, 16'h0001);
      repeat (5) @(negedge clk);
      check("R10 held", 32'(card_req_valid), 1);
      check("R10 cmd", 32'(card_cmd), 32'h11);

      // R8 command and argument registers
      do_reset();
      wr(4'd6, 16'hffff);
      rd(4'd6, d); check("R8 cmd max", 32'(d), 32'h7f);
      wr(4'd6, 16'h0005);
      rd(4'd6, d); check("R8 cmd", 32'(d), 32'h45);
      wr(4'd7, 16'h1234);
      wr(4'd8, 16'habcd);
      wr(4'd7, 16'h5678);
      check("R8 arg", card_arg, 32'h5678abcd);
      wr(4'd8, 16'h0f0f);
      check("R8 arg low", card_arg, 32'h56780f0f);
      rd(4'd7, d); check("R8 argh read", 32'(d), 32'h5678);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule